// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software must service by rewriting a 16-bit timeout value before it runs out. Counting is driven by a slow 32 kHz tick-enable input. That tick passes through a power-of-two prescaler before it reaches a down-counter. The counter runs through two stages in a row:

- The first expiry sets a sticky overflow flag and starts the configured first-stage action.
- The count then reloads and runs a second stage. If software stays silent, that stage ends in its own configured action.

Each stage's action is one of four: nothing, an interrupt request, an SMI request, or a system reset request.

Software reaches the block through a small register bus at three byte offsets: timeout, configuration and status. Each raised action leaves a read-only status flag. The interrupt and SMI outputs stay asserted as long as their flags are set, while the reset request is a single-cycle pulse. A write to the timeout register restarts the first stage and cancels a pending second stage. Writing a timeout of zero stops the watchdog.

Top module: `dual_stage_wdt`

## Requirements
- R1: After synchronous reset every register reads 0 and irq_o, smi_o and rst_req_o are low.
- R2: Offset 0x0 reads back the last timeout written. Offset 0x2 reads back all 16 configuration bits as written, including the unused bits [15:9]. Status bits [7:4] at offset 0x4 read back as written.
- R3: Writing offset 0x0 loads the countdown and restarts stage one. A value of 0 stops the watchdog, so no flag is set however many ticks arrive.
- R4: With prescaler field cfg[3:0] = N (N ≤ 13), each stage ends on the T·2^N-th accepted tick after the timeout write, where T is the timeout value.
- R5: While cfg[8] is 1, ticks are ignored and the countdown and prescaler hold. Clearing it resumes counting from where it stopped.
- R6: At stage-one expiry, status bit 0 (overflow) sets and the action in cfg[5:4] fires. The encoding is 00 none, 01 interrupt (status bit 1), 10 SMI (status bit 2), 11 reset (status bit 3).
- R7: Stage two reloads T and expires after another T·2^N ticks. It sets bit 0 again, fires the action in cfg[7:6] with the same encoding, and then the watchdog stops. A timeout write during stage two cancels it and restarts stage one.
- R8: irq_o and smi_o are high exactly while status bits 1 and 2 are set. rst_req_o is high for the one cycle following a reset-action expiry.
- R9: A status write with bit 0 = 1 clears only the overflow flag. A status write with bit 0 = 0 clears only bits [3:1].
- R10: Status bits [3:1] cannot be set by software writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset: 0x0 timeout, 0x2 config, 0x4 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick_32k_en | input | 1 | One-cycle enable at the slow tick rate |
| irq_o | output | 1 | Interrupt request level |
| smi_o | output | 1 | SMI request level |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: 16-bit count, 4-bit prescaler field, largest usable shift 13. It drives the tick as one-cycle pulses every other clock. It uses timeouts of 1 to 3 with prescaler settings 0 and 2, so a complete two-stage sequence finishes in a few dozen cycles. This makes it practical to run every action encoding through both stages. It also makes the exact expiry tick under division observable, along with cancellation in mid-sequence and both flag-clearing rules.

// File: rtl/wdt_pkg.sv
// Shared types and constants for the two-stage watchdog.
// Assumes a 16-bit register bus with byte offsets for the three registers.
package wdt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_TIMEOUT = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_CONFIG  = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 3'h4;

    // Configuration field positions; software depends on them.
    localparam int CFG_GATE_BIT = 8;
    localparam int CFG_ACT2_LO  = 6;
    localparam int CFG_ACT1_LO  = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_IRQ  = 2'b01,
        ACT_SMI  = 2'b10,
        ACT_RST  = 2'b11
    } wdt_act_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10
    } wdt_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
// Power-of-two divider on the slow tick enable.
// Emits one step per 2^N accepted ticks. Settings above PRE_MAX are treated
// as PRE_MAX. A gated tick is not accepted. sync_clr_i restarts the division.
module wdt_prescaler #(
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             sync_clr_i,
    input  logic [PRE_W-1:0] sel_i,
    output logic             step_o
);
    logic [PRE_MAX-1:0] div_q;
    logic [PRE_W-1:0]   sel_eff;
    logic [PRE_MAX-1:0] mask;
    logic               tick_ok;

    // Clamp the reserved settings and build the low-bit mask.
    always_comb begin
        sel_eff = (sel_i > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : sel_i;
        mask    = ~({PRE_MAX{1'b1}} << sel_eff);
        tick_ok = tick_i && !gate_i;
        step_o  = tick_ok && ((div_q & mask) == mask);
    end

    // Count accepted ticks; clear on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_clr_i) begin
            div_q <= '0;
        end else if (tick_ok) begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && !sync_clr_i) |=> $stable(div_q)); // R5
endmodule

// File: rtl/wdt_countdown.sv
// Two-stage down-counter. A load starts stage one, or goes idle if the value
// is zero. Each expiry reloads the timeout; stage two's expiry goes idle.
// The fire outputs are combinational and are registered by the consumer.
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             step_i,
    output logic             fire1_o,
    output logic             fire2_o
);
    wdt_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;
    logic             active;

    // Decode the final step of the running stage.
    always_comb begin
        last    = (cnt_q == CNT_W'(1));
        active  = (state_q != ST_IDLE);
        fire1_o = step_i && !load_i && last && (state_q == ST_ONE);
        fire2_o = step_i && !load_i && last && (state_q == ST_TWO);
    end

    // Advance the count and the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (load_i) begin
            cnt_q   <= load_val_i;
            state_q <= (load_val_i == '0) ? ST_IDLE : ST_ONE;
        end else if (step_i && active) begin
            if (last) begin
                cnt_q   <= reload_val_i;
                state_q <= (state_q == ST_ONE) ? ST_TWO : ST_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> (state_q == ST_IDLE)); // R3
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !step_i && !load_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/wdt_regs.sv
// Register file, event routing and sticky status.
// The event sets are applied after the software clears, so an expiry in the
// same cycle as a clear wins. Reads decode bus_addr combinationally.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              fire1_i,
    input  logic              fire2_i,
    output logic [CNT_W-1:0]  timeout_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic              load_o,
    output logic              irq_o,
    output logic              smi_o,
    output logic              rst_req_o
);
    logic [CNT_W-1:0]  to_q;
    logic [DATA_W-1:0] cfg_q;
    logic              ovf_q, irq_q, smi_q, rst_q, pulse_q;
    logic [3:0]        sts_rsv_q;
    logic              wr_to, wr_cfg, wr_sts;
    wdt_act_e          act;
    logic              ev_any, ev_irq, ev_smi, ev_rst;

    // Decode writes and route the expiring stage's action.
    always_comb begin
        wr_to  = sel_i && wr_i && (addr_i == OFS_TIMEOUT);
        wr_cfg = sel_i && wr_i && (addr_i == OFS_CONFIG);
        wr_sts = sel_i && wr_i && (addr_i == OFS_STATUS);
        if (fire1_i)      act = wdt_act_e'(cfg_q[CFG_ACT1_LO +: 2]);
        else if (fire2_i) act = wdt_act_e'(cfg_q[CFG_ACT2_LO +: 2]);
        else              act = ACT_NONE;
        ev_any = fire1_i || fire2_i;
        ev_irq = ev_any && (act == ACT_IRQ);
        ev_smi = ev_any && (act == ACT_SMI);
        ev_rst = ev_any && (act == ACT_RST);
    end

    // Timeout and configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q  <= '0;
            cfg_q <= '0;
        end else begin
            if (wr_to)  to_q  <= wdata_i[CNT_W-1:0];
            if (wr_cfg) cfg_q <= wdata_i;
        end
    end

    // Sticky status flags: software clears first, expiry sets last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q     <= 1'b0;
            irq_q     <= 1'b0;
            smi_q     <= 1'b0;
            rst_q     <= 1'b0;
            sts_rsv_q <= '0;
            pulse_q   <= 1'b0;
        end else begin
            if (wr_sts) sts_rsv_q <= wdata_i[7:4];
            if (wr_sts && wdata_i[0]) ovf_q <= 1'b0;
            if (wr_sts && !wdata_i[0]) begin
                irq_q <= 1'b0;
                smi_q <= 1'b0;
                rst_q <= 1'b0;
            end
            if (ev_any) ovf_q <= 1'b1;
            if (ev_irq) irq_q <= 1'b1;
            if (ev_smi) smi_q <= 1'b1;
            if (ev_rst) rst_q <= 1'b1;
            pulse_q <= ev_rst;
        end
    end

    // Read mux.
    always_comb begin
        case (addr_i)
            OFS_TIMEOUT: rdata_o = DATA_W'(to_q);
            OFS_CONFIG:  rdata_o = cfg_q;
            OFS_STATUS:  rdata_o = {8'h00, sts_rsv_q, rst_q, smi_q, irq_q, ovf_q};
            default:     rdata_o = '0;
        endcase
    end

    assign timeout_o = to_q;
    assign cfg_o     = cfg_q;
    assign load_o    = wr_to;
    assign irq_o     = irq_q;
    assign smi_o     = smi_q;
    assign rst_req_o = pulse_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(wr_sts && wdata_i[0])) |=> ovf_q); // R9
    AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(fire1_i || fire2_i)); // R10
    AST_RST_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> $past(fire1_i || fire2_i)); // R8
endmodule

// File: rtl/dual_stage_wdt.sv
// Top of the two-stage watchdog. It joins the register file, the tick
// prescaler and the two-stage countdown. Assumes tick_32k_en is already
// synchronous to clk and high for one cycle per slow tick.
module dual_stage_wdt
    import wdt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tick_32k_en,
    output logic        irq_o,
    output logic        smi_o,
    output logic        rst_req_o
);
    logic [CNT_W-1:0]  timeout;
    logic [DATA_W-1:0] cfg;
    logic              load, step, fire1, fire2;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (bus_sel),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .fire1_i   (fire1),
        .fire2_i   (fire2),
        .timeout_o (timeout),
        .cfg_o     (cfg),
        .load_o    (load),
        .irq_o     (irq_o),
        .smi_o     (smi_o),
        .rst_req_o (rst_req_o)
    );

    wdt_prescaler #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_32k_en),
        .gate_i     (cfg[CFG_GATE_BIT]),
        .sync_clr_i (load),
        .sel_i      (cfg[PRE_W-1:0]),
        .step_o     (step)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .load_val_i   (bus_wdata[CNT_W-1:0]),
        .reload_val_i (timeout),
        .step_i       (step),
        .fire1_o      (fire1),
        .fire2_o      (fire2)
    );
endmodule

// File: tb/tb_dual_stage_wdt.sv
`timescale 1ns/1ps
module tb_dual_stage_wdt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        tick = 1'b0;
    logic        irq_o, smi_o, rst_req_o;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    dual_stage_wdt dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_32k_en(tick), .irq_o(irq_o), .smi_o(smi_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk);
            tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic clear_all();
        wr(3'h4, 16'h0000);
        wr(3'h4, 16'h0001);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(3'h0, d); chk("R1 timeout", d, 16'h0);
        rd(3'h2, d); chk("R1 config", d, 16'h0);
        rd(3'h4, d); chk("R1 status", d, 16'h0);
        chk("R1 outputs", {13'h0, irq_o, smi_o, rst_req_o}, 16'h0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(3'h0, 16'h1234); rd(3'h0, d); chk("R2 timeout readback", d, 16'h1234);
        wr(3'h0, 16'h0000);
        wr(3'h2, 16'hFE3B); rd(3'h2, d); chk("R2 config readback", d, 16'hFE3B);
        wr(3'h2, 16'h0000);
        wr(3'h4, 16'h00A1); rd(3'h4, d); chk("R2 status reserved", d, 16'h00A0);
        wr(3'h4, 16'h000E); rd(3'h4, d); chk("R10 read-only flags", d, 16'h0000);
    endtask

    task automatic t_zero();
        logic [15:0] d;
        wr(3'h2, 16'h0010);
        wr(3'h0, 16'h0000);
        ticks(10);
        rd(3'h4, d); chk("R3 zero timeout idle", d, 16'h0);
        chk("R3 irq idle", {15'h0, irq_o}, 16'h0);
    endtask

    task automatic t_prescale();
        logic [15:0] d;
        wr(3'h2, 16'h0012);
        wr(3'h0, 16'h0002);
        ticks(7);
        rd(3'h4, d); chk("R4 before 2*4 ticks", d, 16'h0);
        ticks(1);
        rd(3'h4, d); chk("R4 at 2*4 ticks", d, 16'h0003);
        chk("R8 irq level", {15'h0, irq_o}, 16'h1);
        wr(3'h4, 16'h0000);
        rd(3'h4, d); chk("R9 write0 clears flags only", d, 16'h0001);
        chk("R8 irq follows flag", {15'h0, irq_o}, 16'h0);
        wr(3'h4, 16'h0001);
        rd(3'h4, d); chk("R9 write1 clears overflow", d, 16'h0000);
        wr(3'h0, 16'h0000);
    endtask

    task automatic t_gate();
        logic [15:0] d;
        wr(3'h2, 16'h0110);
        wr(3'h0, 16'h0001);
        ticks(4);
        rd(3'h4, d); chk("R5 gated no expiry", d, 16'h0);
        wr(3'h2, 16'h0010);
        ticks(1);
        rd(3'h4, d); chk("R5 resumes", d, 16'h0003);
        wr(3'h0, 16'h0000);
        clear_all();
    endtask

    task automatic stage_watch(input string req, input int t);
        logic [15:0] d;
        logic [15:0] exp;
        exp = 16'h0001 | ((t != 0) ? (16'h1 << t) : 16'h0);
        ticks(2);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        chk({req, " reset pulse"}, {15'h0, rst_req_o}, {15'h0, (t == 3)});
        @(negedge clk);
        chk({req, " reset pulse ends"}, {15'h0, rst_req_o}, 16'h0);
        rd(3'h4, d); chk({req, " status"}, d, exp);
        chk({req, " irq/smi"}, {14'h0, irq_o, smi_o}, {14'h0, (t == 1), (t == 2)});
    endtask

    task automatic t_stages();
        logic [15:0] d;
        for (int t1 = 0; t1 < 4; t1++) begin
            int t2;
            t2 = 3 - t1;
            wr(3'h2, 16'((t2 << 6) | (t1 << 4)));
            wr(3'h0, 16'h0003);
            stage_watch("R6 stage one", t1);
            clear_all();
            stage_watch("R7 stage two", t2);
            clear_all();
            ticks(6);
            rd(3'h4, d); chk("R7 stops after stage two", d, 16'h0);
            wr(3'h0, 16'h0000);
        end
    endtask

    task automatic t_cancel();
        logic [15:0] d;
        wr(3'h2, 16'h00D0);
        wr(3'h0, 16'h0002);
        ticks(2);
        rd(3'h4, d); chk("R6 stage one irq", d, 16'h0003);
        clear_all();
        wr(3'h0, 16'h0002);
        ticks(2);
        rd(3'h4, d); chk("R7 cancel restarts stage one", d, 16'h0003);
        repeat (20) @(negedge clk);
        chk("R8 irq holds", {15'h0, irq_o}, 16'h1);
        wr(3'h4, 16'h0001);
        chk("R9 ovf clear keeps irq", {15'h0, irq_o}, 16'h1);
        wr(3'h4, 16'h0000);
        chk("R9 flag clear drops irq", {15'h0, irq_o}, 16'h0);
        wr(3'h0, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_zero();
        t_prescale();
        t_gate();
        t_stages();
        t_cancel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule